// File: doc/BRIEF.md
# Checkpointed Single-Clock FIFO

This block is a synchronous first-in, first-out buffer with one extra saved pointer on each side. The read side holds a reread checkpoint and the write side holds a rewrite checkpoint. A consumer can mark its position, read a run of words, and then jump back to the mark to read the same run again. A producer can mark its position, write a run of words, and then jump back to discard that run and write it over.

Each checkpoint is captured from the live pointer while its save input is high. The live pointer is reloaded from the checkpoint while the matching active-low restore input is low. Live pointers carry one bit more than the storage address. The fill level is their difference modulo twice the depth, so the empty and full flags follow straight from the two registered pointers. The read port is show-ahead: the oldest word is always present on the output, and a pop moves on to the next one.

Top module: `ckpt_fifo`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising clock edge), empty is 1, full is 0 and level is 0.
- R2: Words leave in the order they were accepted. rd_data shows the oldest stored word, and each accepted pop advances to the next word.
- R3: full is 1 exactly when level equals the depth (16 by default). A push while full is ignored: level stays the same and no stored word changes.
- R4: A pop while empty is ignored: level stays 0, and the next pushed word is the one presented on rd_data.
- R5: A clock edge with save_rd high stores the current read pointer in the reread checkpoint. A clock edge with restore_rd_n low loads the read pointer from it, so the words from the mark onward are read again in order.
- R6: A clock edge with save_wr high stores the current write pointer in the rewrite checkpoint. A clock edge with restore_wr_n low loads the write pointer from it, which drops the words written after the mark. Later pushes fill those slots.
- R7: A restore takes priority over a pop or push on the same side in the same cycle. The pointer takes the checkpoint value and the pop or push has no effect.
- R8: level equals write pointer minus read pointer modulo 2×depth. level, empty and full reflect a push, a pop or a restore right after the clock edge that applied it, and empty and full are never both 1.
- R9: Reset clears both checkpoints and both live pointers to zero. A restore straight after reset returns the pointer to slot 0.
- R10: When save and restore are both active on one side in the same cycle, the pointer and its checkpoint exchange values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Write request |
| wr_data | input | DATA_W (18) | Word to store |
| pop | input | 1 | Read request |
| rd_data | output | DATA_W (18) | Oldest stored word (show-ahead) |
| save_rd | input | 1 | Capture read pointer into reread checkpoint |
| restore_rd_n | input | 1 | Active low: reload read pointer from checkpoint |
| save_wr | input | 1 | Capture write pointer into rewrite checkpoint |
| restore_wr_n | input | 1 | Active low: reload write pointer from checkpoint |
| level | output | ADDR_W+1 (5) | Stored word count |
| empty | output | 1 | No words stored |
| full | output | 1 | Depth words stored |

## Verification
Plain streams of distinct words, both short and long enough to fill the buffer and wrap the pointers, separate correct ordering from lost, duplicated or overwritten words. The same tests also push into a full buffer and pop from an empty one. Read-side marks followed by partial reads and a restore show whether the pointer lands on the marked word and whether level grows back. Write-side marks with a rewind and fresh pushes show whether discarded words really disappear. Cycles where restore coincides with pop, push or save separate restore priority and the pointer/checkpoint exchange from the plain paths. A reset taken while a checkpoint holds a nonzero mark shows whether reset clears it.

// File: rtl/ckpt_fifo_pkg.sv
// Package: shared types for the checkpointed FIFO.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ckpt_fifo_pkg;

    // Action a live pointer takes on the next clock edge.
    typedef enum logic [1:0] {
        PA_HOLD = 2'd0,
        PA_STEP = 2'd1,
        PA_LOAD = 2'd2
    } ptr_action_e;

endpackage

// File: rtl/ckpt_ptr_unit.sv
// Module: one live pointer plus its checkpoint register.
// The restore input (active low) overrides a step request. The save input
// captures the pre-edge pointer value. Save and restore together exchange
// the two values. Assumes the step request is already qualified by the
// caller's full/empty condition.
module ckpt_ptr_unit
    import ckpt_fifo_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_req,
    input  logic             restore_n,
    input  logic             save,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] chk,
    output logic             advanced
);

    ptr_action_e action;

    // Choose the pointer action: restore wins over a step.
    always_comb begin
        if (!restore_n)
            action = PA_LOAD;
        else if (step_req)
            action = PA_STEP;
        else
            action = PA_HOLD;
    end

    assign advanced = (action == PA_STEP);

    // Update the live pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else begin
            case (action)
                PA_LOAD: ptr <= chk;
                PA_STEP: ptr <= ptr + 1'b1;
                default: ptr <= ptr;
            endcase
        end
    end

    // Capture the checkpoint from the pre-edge live pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk <= '0;
        else if (save)
            chk <= ptr;
    end

    AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_n |=> ptr == $past(chk)); // R7
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && restore_n) |=> ptr == $past(ptr) + 1'b1); // R2
    AST_SAVE_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        save |=> chk == $past(ptr)); // R5
    AST_CHK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !save |=> $stable(chk)); // R6

endmodule

// File: rtl/ckpt_store.sv
// Module: word storage, one synchronous write port and one
// asynchronous (show-ahead) read port. Contents are not reset; the
// pointers decide which slots hold valid data.
module ckpt_store #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write one word per accepted push.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Present the word at the read address.
    assign rdata = mem[raddr];

endmodule

// File: rtl/ckpt_level.sv
// Module: fill level and flags from the two extended pointers.
// Assumes both pointers are ADDR_W+1 bits. Purely combinational, so
// flags follow the registered pointers from the edge that moved them.
module ckpt_level #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W:0] wr_ptr,
    input  logic [ADDR_W:0] rd_ptr,
    output logic [ADDR_W:0] level,
    output logic            empty,
    output logic            full
);

    localparam logic [ADDR_W:0] DEPTH_V = 1 << ADDR_W;

    // Derive level modulo twice the depth, then the flags.
    always_comb begin
        level = wr_ptr - rd_ptr;
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[ADDR_W] != rd_ptr[ADDR_W]) &&
                (wr_ptr[ADDR_W-1:0] == rd_ptr[ADDR_W-1:0]);
    end

endmodule

// File: rtl/ckpt_fifo.sv
// Module: top of the checkpointed single-clock FIFO.
// Two pointer units (read, write) each carry a checkpoint. Storage is a
// register array with show-ahead read. Assumes the user does not restore a
// pointer past data that has since been overwritten or freed.
module ckpt_fifo #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic              save_rd,
    input  logic              restore_rd_n,
    input  logic              save_wr,
    input  logic              restore_wr_n,
    output logic [ADDR_W:0]   level,
    output logic              empty,
    output logic              full
);

    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_chk, rd_chk;
    logic             wr_adv, rd_adv;

    ckpt_ptr_unit #(.PTR_W(PTR_W)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n),
        .step_req(push && !full), .restore_n(restore_wr_n), .save(save_wr),
        .ptr(wr_ptr), .chk(wr_chk), .advanced(wr_adv)
    );

    ckpt_ptr_unit #(.PTR_W(PTR_W)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n),
        .step_req(pop && !empty), .restore_n(restore_rd_n), .save(save_rd),
        .ptr(rd_ptr), .chk(rd_chk), .advanced(rd_adv)
    );

    ckpt_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(wr_adv),
        .waddr(wr_ptr[ADDR_W-1:0]), .wdata(wr_data),
        .raddr(rd_ptr[ADDR_W-1:0]), .rdata(rd_data)
    );

    ckpt_level #(.ADDR_W(ADDR_W)) u_level (
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .level(level), .empty(empty), .full(full)
    );

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && restore_wr_n) |=> $stable(wr_ptr)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && restore_rd_n) |=> $stable(rd_ptr)); // R4
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full)); // R8
    AST_RD_ADV_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |-> !empty && restore_rd_n); // R7

endmodule

// File: tb/test_ckpt_fifo.sv
module test_ckpt_fifo;

    localparam int DATA_W = 18;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push = 1'b0, pop = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              save_rd = 1'b0, restore_rd_n = 1'b1;
    logic              save_wr = 1'b0, restore_wr_n = 1'b1;
    logic [ADDR_W:0]   level;
    logic              empty, full;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ckpt_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ckpt_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wr_data(wr_data),
        .pop(pop), .rd_data(rd_data),
        .save_rd(save_rd), .restore_rd_n(restore_rd_n),
        .save_wr(save_wr), .restore_wr_n(restore_wr_n),
        .level(level), .empty(empty), .full(full)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic do_push(input logic [DATA_W-1:0] d);
        push = 1'b1;
        wr_data = d;
        tick();
        push = 1'b0;
    endtask

    task automatic pop_expect(input logic [DATA_W-1:0] d, input string req);
        chk(req, rd_data, d);
        pop = 1'b1;
        tick();
        pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 level", level, 0);
    endtask

    // R2, R8: basic ordering and level tracking
    task automatic t_order();
        for (int i = 0; i < 5; i++) do_push(18'h100 + i);
        chk("R8 level after 5 pushes", level, 5);
        chk("R8 not empty", empty, 0);
        for (int i = 0; i < 5; i++) pop_expect(18'h100 + i, "R2 order");
        chk("R8 empty after drain", empty, 1);
    endtask

    // R3, R4: full and empty protection
    task automatic t_full_empty();
        for (int i = 0; i < DEPTH; i++) do_push(18'h200 + i);
        chk("R3 full flag", full, 1);
        chk("R3 level at depth", level, DEPTH);
        do_push(18'h3FFFF);
        chk("R3 level after push while full", level, DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_expect(18'h200 + i, "R3 contents intact");
        chk("R8 empty after full drain", empty, 1);
        pop = 1'b1;
        tick();
        pop = 1'b0;
        chk("R4 level after pop while empty", level, 0);
        do_push(18'h0ABC);
        chk("R4 head after empty pop", rd_data, 18'h0ABC);
        chk("R4 level one", level, 1);
        pop_expect(18'h0ABC, "R4 drain");
    endtask

    // R5, R7: reread a block, restore beats pop
    task automatic t_reread();
        for (int i = 0; i < 6; i++) do_push(18'h300 + i);
        save_rd = 1'b1; tick(); save_rd = 1'b0;
        for (int i = 0; i < 3; i++) pop_expect(18'h300 + i, "R5 first pass");
        chk("R8 level after partial read", level, 3);
        restore_rd_n = 1'b0; tick(); restore_rd_n = 1'b1;
        chk("R5 level after restore", level, 6);
        chk("R5 head after restore", rd_data, 18'h300);
        for (int i = 0; i < 6; i++) pop_expect(18'h300 + i, "R5 second pass");
        chk("R5 empty", empty, 1);
        for (int i = 0; i < 4; i++) do_push(18'h340 + i);
        save_rd = 1'b1; tick(); save_rd = 1'b0;
        pop_expect(18'h340, "R7 setup");
        restore_rd_n = 1'b0; pop = 1'b1; tick(); restore_rd_n = 1'b1; pop = 1'b0;
        chk("R7 level restore over pop", level, 4);
        chk("R7 head restore over pop", rd_data, 18'h340);
        for (int i = 0; i < 4; i++) pop_expect(18'h340 + i, "R7 drain");
    endtask

    // R6, R7: rewrite a block, restore beats push
    task automatic t_rewrite();
        do_push(18'h400);
        do_push(18'h401);
        save_wr = 1'b1; tick(); save_wr = 1'b0;
        for (int i = 0; i < 3; i++) do_push(18'h3DEAD - i);
        chk("R8 level before rewind", level, 5);
        restore_wr_n = 1'b0; tick(); restore_wr_n = 1'b1;
        chk("R6 level after rewind", level, 2);
        do_push(18'h402);
        do_push(18'h403);
        for (int i = 0; i < 4; i++) pop_expect(18'h400 + i, "R6 rewritten stream");
        save_wr = 1'b1; tick(); save_wr = 1'b0;
        push = 1'b1; wr_data = 18'h1FFFF; restore_wr_n = 1'b0;
        tick();
        push = 1'b0; restore_wr_n = 1'b1;
        chk("R7 level restore over push", level, 0);
        chk("R7 empty restore over push", empty, 1);
    endtask

    // R9: reset clears checkpoints
    task automatic t_reset_ckpt();
        for (int i = 0; i < 3; i++) do_push(18'h500 + i);
        pop_expect(18'h500, "R9 setup");
        save_rd = 1'b1; save_wr = 1'b1; tick(); save_rd = 1'b0; save_wr = 1'b0;
        do_reset();
        do_push(18'h600);
        do_push(18'h601);
        pop_expect(18'h600, "R9 post-reset");
        restore_rd_n = 1'b0; tick(); restore_rd_n = 1'b1;
        chk("R9 level after read restore", level, 2);
        chk("R9 head after read restore", rd_data, 18'h600);
        restore_wr_n = 1'b0; tick(); restore_wr_n = 1'b1;
        chk("R9 level after write restore", level, 0);
    endtask

    // R10: simultaneous save and restore exchange pointer and checkpoint
    task automatic t_swap();
        for (int i = 0; i < 4; i++) do_push(18'h700 + i);
        save_rd = 1'b1; tick(); save_rd = 1'b0;
        pop_expect(18'h700, "R10 setup");
        pop_expect(18'h701, "R10 setup");
        save_rd = 1'b1; restore_rd_n = 1'b0; tick(); save_rd = 1'b0; restore_rd_n = 1'b1;
        chk("R10 level after exchange", level, 4);
        chk("R10 head after exchange", rd_data, 18'h700);
        restore_rd_n = 1'b0; tick(); restore_rd_n = 1'b1;
        chk("R10 level after second restore", level, 2);
        chk("R10 head after second restore", rd_data, 18'h702);
        pop_expect(18'h702, "R10 drain");
        pop_expect(18'h703, "R10 drain");
    endtask

    initial begin
        t_reset();
        t_order();
        t_full_empty();
        t_reread();
        t_rewrite();
        t_reset_ckpt();
        t_swap();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule